// File: doc/BRIEF.md
# Video-Mode Display Frame Packet Sequencer

This block produces the complete packet stream for one video-mode display frame on a serial display link. It uses the non-burst timing style, where sync pulses are sent as explicit start and end events. A frame runs through four vertical regions: sync lines, back-porch lines, active lines and front-porch lines. Each line is built from 4-byte short packets and long packets. The lengths of the horizontal blanking gaps are given as byte (word) counts, not as pixel-clock periods.

Before a frame, the host drives the line count of each region, the word counts of the horizontal sync, back porch, active data, front porch and low-power-gap packets, a 2-bit virtual channel and a sync-event mode bit, and then pulses `start`. The block emits header, payload and checksum bytes on a byte-wide valid/ready output. During each active line it pulls RGB888 pixel bytes from a valid/ready pixel input and passes them straight into the pixel packet.

Top module: `dsi_vid_seq`

## Requirements
- R1: A frame emits the sync region lines, then the back-porch lines, then the active lines, then the front-porch lines. Each non-active line in pulse mode consists of a sync-start short packet, a blanking long packet of `hsa_wc` bytes, a sync-end short packet (data type 0x31), and a blanking long packet of `bllp_wc` bytes.
- R2: The first line of the sync region starts with data type 0x01. The first line of the back-porch region starts with data type 0x11. Every other line starts with data type 0x21.
- R3: In pulse mode, each active line consists of: 0x21 short packet, `hsa_wc` blanking, 0x31 short packet, `hbp_wc` blanking, exactly one pixel long packet (data type 0x3E, word count `hact_wc`, whose payload is the next `hact_wc` bytes taken from the pixel input in order), and `hfp_wc` blanking.
- R4: A long packet has four parts, in this order. First, byte 0 = {vc[1:0], dt[5:0]}. Second, the 16-bit word count, low byte first. Third, the ECC byte. Fourth, the payload, followed by two 0x00 checksum bytes. Blanking packets use data type 0x19 and an all-zero payload. A word count of 0 gives a packet with only the header and checksum.
- R5: A short packet is {vc, dt}, 0x00, 0x00, ECC.
- R6: The ECC byte is the 6-bit Hamming parity over the 24 header bits (byte 0 is bits 7:0), with bits 7:6 equal to zero. For example, `01 00 00` gives 0x07 and `21 00 00` gives 0x12.
- R7: When `sync_event` is 1, every line drops the `hsa_wc` blanking packet and the 0x31 sync-end packet. The sync-start packet is followed directly by the next packet.
- R8: Configuration is captured only when `start` is seen while the block is idle. A `start` pulse or configuration change during a frame does not change the stream or `cfg_err`.
- R9: If an accepted start has `bllp_wc != hbp_wc + hact_wc + hfp_wc`, `hact_wc` not a multiple of 3, or zero active lines, the block raises `cfg_err` on the next cycle, emits no bytes and stays idle. The next accepted start clears `cfg_err`.
- R10: While `out_valid` is high and `out_ready` is low, `out_data` holds its value. `pix_ready` is high only inside a pixel payload and only together with `out_ready`.
- R11: After reset, `busy`, `out_valid`, `pix_ready` and `cfg_err` are 0. `busy` goes high the cycle after an accepted valid start and stays high until the last byte of the frame has been taken.
- R12: A vertical region with a line count of zero is skipped. For example, with no sync lines, the frame opens with the 0x11 packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Frame request, sampled while idle |
| sync_event | input | 1 | 1 selects sync-event mode |
| vchan | input | 2 | Virtual channel for every header |
| vsa_lines | input | LCNT_W | Sync region line count |
| vbp_lines | input | LCNT_W | Back-porch region line count |
| act_lines | input | LCNT_W | Active line count |
| vfp_lines | input | LCNT_W | Front-porch region line count |
| hsa_wc | input | 16 | Horizontal sync blanking bytes |
| hbp_wc | input | 16 | Horizontal back-porch bytes |
| hact_wc | input | 16 | Pixel payload bytes per line |
| hfp_wc | input | 16 | Horizontal front-porch bytes |
| bllp_wc | input | 16 | Low-power-gap blanking bytes |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Output byte accepted |
| out_data | output | 8 | Output byte |
| pix_valid | input | 1 | Pixel byte valid |
| pix_ready | output | 1 | Pixel byte taken |
| pix_data | input | 8 | Pixel byte |
| busy | output | 1 | Frame in progress |
| cfg_err | output | 1 | Last accepted start had bad counts |

## Verification
`busy` and `cfg_err` are due one edge after the edge that samples `start`. The bench therefore drives `start` just after a rising edge and reads both flags at the next falling edge. The first header byte appears two edges after the start edge. Each later byte depends on the ready and pixel handshakes, so the bench does not predict byte timing. Instead it records every byte transferred at a falling edge where valid and ready are both high, and it compares the complete recorded frame, including fixed header offsets, against a stream built from the requirements once `busy` has dropped. For configuration errors, the bench waits twenty cycles after the rejected start and then confirms that no byte came out.

// File: rtl/dsi_seq_pkg.sv
`timescale 1ns/1ps
package dsi_seq_pkg;
  localparam int WC_W = 16;

  localparam logic [5:0] DT_VSS   = 6'h01;
  localparam logic [5:0] DT_VSE   = 6'h11;
  localparam logic [5:0] DT_HSS   = 6'h21;
  localparam logic [5:0] DT_HSE   = 6'h31;
  localparam logic [5:0] DT_BLANK = 6'h19;
  localparam logic [5:0] DT_RGB   = 6'h3E;

  typedef enum logic [1:0] {RG_VSA, RG_VBP, RG_ACT, RG_VFP} region_e;
  typedef enum logic [1:0] {SR_IDLE, SR_HDR, SR_PAY, SR_CKS} ser_st_e;

  typedef struct packed {
    logic [5:0]      dt;
    logic [WC_W-1:0] wc;
    logic            is_long;
    logic            is_pix;
  } pkt_desc_t;

  // parity masks over header bits 23:0, one per ECC bit
  function automatic logic [7:0] hdr_ecc(input logic [23:0] d);
    logic [7:0] e;
    e[0] = ^(d & 24'hF12CB7);
    e[1] = ^(d & 24'hF2555B);
    e[2] = ^(d & 24'h749A6D);
    e[3] = ^(d & 24'hB8E38E);
    e[4] = ^(d & 24'hDF03F0);
    e[5] = ^(d & 24'hEFFC00);
    e[7:6] = 2'b00;
    return e;
  endfunction
endpackage

// File: rtl/dsi_seq_ecc.sv
`timescale 1ns/1ps
module dsi_seq_ecc
  import dsi_seq_pkg::*;
(
  input  logic [23:0] hdr,
  output logic [7:0]  ecc
);
  assign ecc = hdr_ecc(hdr);
endmodule

// File: rtl/dsi_seq_ctrl.sv
`timescale 1ns/1ps
module dsi_seq_ctrl
  import dsi_seq_pkg::*;
#(
  parameter int LCNT_W = 10
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              busy_i,
  input  logic              sync_event,
  input  logic [1:0]        vchan,
  input  logic [LCNT_W-1:0] vsa_lines,
  input  logic [LCNT_W-1:0] vbp_lines,
  input  logic [LCNT_W-1:0] act_lines,
  input  logic [LCNT_W-1:0] vfp_lines,
  input  logic [WC_W-1:0]   hsa_wc,
  input  logic [WC_W-1:0]   hbp_wc,
  input  logic [WC_W-1:0]   hact_wc,
  input  logic [WC_W-1:0]   hfp_wc,
  input  logic [WC_W-1:0]   bllp_wc,
  input  logic              desc_take,
  output logic              desc_valid,
  output pkt_desc_t         desc,
  output logic [1:0]        vc_o,
  output logic              cfg_err
);
  localparam logic [LCNT_W-1:0] L_ONE = LCNT_W'(1);
  localparam int SUM_W = WC_W + 2;

  // latched frame configuration
  logic              sev_q;
  logic [1:0]        vc_q;
  logic [LCNT_W-1:0] vsa_q, vbp_q, act_q, vfp_q;
  logic [WC_W-1:0]   hsa_q, hbp_q, hact_q, hfp_q, bllp_q;

  logic              run_q, run_d;
  region_e           rg_q, rg_d;
  logic [LCNT_W-1:0] ln_q, ln_d;
  logic [2:0]        st_q, st_d;
  logic              err_q;

  logic              accept, cfg_ok, go;
  logic [SUM_W-1:0]  gap_sum;
  region_e           first_rg, nxt_rg;
  logic              nxt_ok, last_step, last_line;
  logic [LCNT_W-1:0] cur_lines;
  logic [2:0]        step_nxt;

  assign gap_sum  = SUM_W'(hbp_wc) + SUM_W'(hact_wc) + SUM_W'(hfp_wc);
  assign cfg_ok   = (gap_sum == SUM_W'(bllp_wc)) && ((hact_wc % 16'd3) == '0)
                    && (act_lines != '0);
  assign accept   = start & ~busy_i;
  assign go       = accept & cfg_ok;
  assign first_rg = (vsa_lines != '0) ? RG_VSA :
                    (vbp_lines != '0) ? RG_VBP : RG_ACT;

  always_comb begin
    cur_lines = act_q;
    nxt_rg    = RG_ACT;
    nxt_ok    = 1'b1;
    case (rg_q)
      RG_VSA: begin cur_lines = vsa_q; nxt_rg = (vbp_q != '0) ? RG_VBP : RG_ACT; end
      RG_VBP: begin cur_lines = vbp_q; nxt_rg = RG_ACT; end
      RG_ACT: begin cur_lines = act_q; nxt_rg = RG_VFP; nxt_ok = (vfp_q != '0); end
      default: begin cur_lines = vfp_q; nxt_rg = RG_VFP; nxt_ok = 1'b0; end
    endcase
  end

  assign last_step = (rg_q == RG_ACT) ? (st_q == 3'd5) : (st_q == 3'd3);
  assign last_line = (ln_q == cur_lines - L_ONE);
  assign step_nxt  = (st_q == 3'd0 && sev_q) ? 3'd3 : st_q + 3'd1;

  // packet descriptor for the current step of the current line
  always_comb begin
    desc = '{dt: DT_HSS, wc: '0, is_long: 1'b0, is_pix: 1'b0};
    case (st_q)
      3'd0: begin
        if (ln_q == '0 && rg_q == RG_VSA)      desc.dt = DT_VSS;
        else if (ln_q == '0 && rg_q == RG_VBP) desc.dt = DT_VSE;
      end
      3'd1: desc = '{dt: DT_BLANK, wc: hsa_q, is_long: 1'b1, is_pix: 1'b0};
      3'd2: desc.dt = DT_HSE;
      3'd3: desc = '{dt: DT_BLANK, wc: (rg_q == RG_ACT) ? hbp_q : bllp_q,
                     is_long: 1'b1, is_pix: 1'b0};
      3'd4: desc = '{dt: DT_RGB, wc: hact_q, is_long: 1'b1, is_pix: 1'b1};
      default: desc = '{dt: DT_BLANK, wc: hfp_q, is_long: 1'b1, is_pix: 1'b0};
    endcase
  end

  always_comb begin
    run_d = run_q;
    rg_d  = rg_q;
    ln_d  = ln_q;
    st_d  = st_q;
    if (go) begin
      run_d = 1'b1;
      rg_d  = first_rg;
      ln_d  = '0;
      st_d  = 3'd0;
    end else if (run_q && desc_take) begin
      if (last_step) begin
        st_d = 3'd0;
        if (last_line) begin
          ln_d  = '0;
          rg_d  = nxt_rg;
          run_d = nxt_ok;
        end else begin
          ln_d = ln_q + L_ONE;
        end
      end else begin
        st_d = step_nxt;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      rg_q  <= RG_VSA;
      ln_q  <= '0;
      st_q  <= '0;
      err_q <= 1'b0;
    end else begin
      run_q <= run_d;
      rg_q  <= rg_d;
      ln_q  <= ln_d;
      st_q  <= st_d;
      if (accept) err_q <= ~cfg_ok;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sev_q <= 1'b0; vc_q <= '0;
      vsa_q <= '0; vbp_q <= '0; act_q <= '0; vfp_q <= '0;
      hsa_q <= '0; hbp_q <= '0; hact_q <= '0; hfp_q <= '0; bllp_q <= '0;
    end else if (go) begin
      sev_q <= sync_event; vc_q <= vchan;
      vsa_q <= vsa_lines; vbp_q <= vbp_lines; act_q <= act_lines; vfp_q <= vfp_lines;
      hsa_q <= hsa_wc; hbp_q <= hbp_wc; hact_q <= hact_wc; hfp_q <= hfp_wc;
      bllp_q <= bllp_wc;
    end
  end

  assign desc_valid = run_q;
  assign vc_o       = vc_q;
  assign cfg_err    = err_q;
endmodule

// File: rtl/dsi_seq_ser.sv
`timescale 1ns/1ps
module dsi_seq_ser
  import dsi_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       desc_valid,
  input  pkt_desc_t  desc,
  input  logic [1:0] vc,
  output logic       desc_take,
  output logic       out_valid,
  output logic [7:0] out_data,
  input  logic       out_ready,
  input  logic [7:0] pix_data,
  input  logic       pix_valid,
  output logic       pix_ready,
  output logic       busy
);
  ser_st_e         st_q, st_d;
  pkt_desc_t       d_q;
  logic [1:0]      idx_q, idx_d;
  logic [WC_W-1:0] cnt_q, cnt_d;
  logic [23:0]     hdr;
  logic [7:0]      ecc;
  logic            fire;

  assign hdr = {d_q.wc, vc, d_q.dt};

  dsi_seq_ecc u_ecc (.hdr(hdr), .ecc(ecc));

  assign desc_take = (st_q == SR_IDLE) & desc_valid;

  always_comb begin
    out_valid = 1'b0;
    out_data  = 8'h00;
    pix_ready = 1'b0;
    case (st_q)
      SR_HDR: begin
        out_valid = 1'b1;
        case (idx_q)
          2'd0:    out_data = hdr[7:0];
          2'd1:    out_data = hdr[15:8];
          2'd2:    out_data = hdr[23:16];
          default: out_data = ecc;
        endcase
      end
      SR_PAY: begin
        if (d_q.is_pix) begin
          out_valid = pix_valid;
          out_data  = pix_data;
          pix_ready = out_ready;
        end else begin
          out_valid = 1'b1;
        end
      end
      SR_CKS:  out_valid = 1'b1;
      default: out_valid = 1'b0;
    endcase
  end

  assign fire = out_valid & out_ready;

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    cnt_d = cnt_q;
    case (st_q)
      SR_IDLE: if (desc_valid) begin st_d = SR_HDR; idx_d = 2'd0; end
      SR_HDR: if (fire) begin
        if (idx_q == 2'd3) begin
          idx_d = 2'd0;
          cnt_d = '0;
          if (!d_q.is_long)       st_d = SR_IDLE;
          else if (d_q.wc == '0)  st_d = SR_CKS;
          else                    st_d = SR_PAY;
        end else begin
          idx_d = idx_q + 2'd1;
        end
      end
      SR_PAY: if (fire) begin
        if (cnt_q == d_q.wc - 16'd1) begin st_d = SR_CKS; idx_d = 2'd0; end
        else cnt_d = cnt_q + 16'd1;
      end
      default: if (fire) begin
        if (idx_q == 2'd1) st_d = SR_IDLE;
        else               idx_d = idx_q + 2'd1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SR_IDLE;
      idx_q <= '0;
      cnt_q <= '0;
      d_q   <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      cnt_q <= cnt_d;
      if (desc_take) d_q <= desc;
    end
  end

  assign busy = (st_q != SR_IDLE);
endmodule

// File: rtl/dsi_vid_seq.sv
`timescale 1ns/1ps
module dsi_vid_seq
  import dsi_seq_pkg::*;
#(
  parameter int LCNT_W = 10
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              sync_event,
  input  logic [1:0]        vchan,
  input  logic [LCNT_W-1:0] vsa_lines,
  input  logic [LCNT_W-1:0] vbp_lines,
  input  logic [LCNT_W-1:0] act_lines,
  input  logic [LCNT_W-1:0] vfp_lines,
  input  logic [15:0]       hsa_wc,
  input  logic [15:0]       hbp_wc,
  input  logic [15:0]       hact_wc,
  input  logic [15:0]       hfp_wc,
  input  logic [15:0]       bllp_wc,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  input  logic              pix_valid,
  output logic              pix_ready,
  input  logic [7:0]        pix_data,
  output logic              busy,
  output logic              cfg_err
);
  logic      desc_valid, desc_take, ser_busy;
  pkt_desc_t desc;
  logic [1:0] vc_l;

  assign busy = desc_valid | ser_busy;

  dsi_seq_ctrl #(.LCNT_W(LCNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .busy_i(busy),
    .sync_event(sync_event), .vchan(vchan),
    .vsa_lines(vsa_lines), .vbp_lines(vbp_lines),
    .act_lines(act_lines), .vfp_lines(vfp_lines),
    .hsa_wc(hsa_wc), .hbp_wc(hbp_wc), .hact_wc(hact_wc),
    .hfp_wc(hfp_wc), .bllp_wc(bllp_wc),
    .desc_take(desc_take), .desc_valid(desc_valid), .desc(desc),
    .vc_o(vc_l), .cfg_err(cfg_err)
  );

  dsi_seq_ser u_ser (
    .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc(desc),
    .vc(vc_l), .desc_take(desc_take), .out_valid(out_valid),
    .out_data(out_data), .out_ready(out_ready), .pix_data(pix_data),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .busy(ser_busy)
  );
endmodule

// File: rtl/dsi_seq_checker.sv
`timescale 1ns/1ps
module dsi_seq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       cfg_err,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       pix_ready
);
  // R10: stalled output byte is held
  a_r10_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R10: pixels are taken only when the output side takes a byte
  a_r10_pix_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ready |-> out_ready);

  // R11: bytes only appear inside a frame
  a_r11_out_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> busy);

  // R9: a rejected configuration leaves the block idle
  a_r9_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !busy);

  // R8: start during a frame leaves the error flag alone
  a_r8_busy_keeps_err: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(cfg_err));
endmodule

bind dsi_vid_seq dsi_seq_checker u_chk (.*);

// File: tb/tb_dsi_vid_seq.sv
`timescale 1ns/1ps
module tb_dsi_vid_seq;
  localparam int LW = 10;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0, sync_event = 1'b0;
  logic [1:0] vchan = '0;
  logic [LW-1:0] vsa_lines = '0, vbp_lines = '0, act_lines = '0, vfp_lines = '0;
  logic [15:0] hsa_wc = '0, hbp_wc = '0, hact_wc = '0, hfp_wc = '0, bllp_wc = '0;
  logic out_valid, pix_ready, busy, cfg_err;
  logic out_ready = 1'b0, pix_valid = 1'b0;
  logic [7:0] out_data, pix_data = '0;

  dsi_vid_seq #(.LCNT_W(LW)) dut (.*);

  int n_chk = 0, n_fail = 0;
  logic [7:0] got_q[$];
  logic [7:0] exp_q[$];
  int pix_cnt = 0, mdl_pix = 0;
  bit pix_fire = 0, throttle = 0;
  logic [7:0] lfsr = 8'hA5;

  // frame configuration used by both the model and the stimulus
  int c_sev, c_vc, c_vsa, c_vbp, c_vact, c_vfp, c_hsa, c_hbp, c_hact, c_hfp, c_bllp;

  function automatic logic [7:0] pix_val(int n);
    return 8'(n * 5 + 1);
  endfunction

  function automatic logic [7:0] ecc_ref(logic [23:0] d);
    logic [7:0] e;
    e[0] = d[0]^d[1]^d[2]^d[4]^d[5]^d[7]^d[10]^d[11]^d[13]^d[16]^d[20]^d[21]^d[22]^d[23];
    e[1] = d[0]^d[1]^d[3]^d[4]^d[6]^d[8]^d[10]^d[12]^d[14]^d[17]^d[20]^d[21]^d[22]^d[23];
    e[2] = d[0]^d[2]^d[3]^d[5]^d[6]^d[9]^d[11]^d[12]^d[15]^d[18]^d[20]^d[21]^d[22];
    e[3] = d[1]^d[2]^d[3]^d[7]^d[8]^d[9]^d[13]^d[14]^d[15]^d[19]^d[20]^d[21]^d[23];
    e[4] = d[4]^d[5]^d[6]^d[7]^d[8]^d[9]^d[16]^d[17]^d[18]^d[19]^d[20]^d[22]^d[23];
    e[5] = d[10]^d[11]^d[12]^d[13]^d[14]^d[15]^d[16]^d[17]^d[18]^d[19]^d[21]^d[22]^d[23];
    e[7:6] = 2'b00;
    return e;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // capture and handshake sampling, away from the rising edge
  always @(negedge clk) begin
    pix_fire = pix_valid && pix_ready;
    if (out_valid && out_ready) got_q.push_back(out_data);
  end

  // pixel source and output sink, updated just after the rising edge
  always @(posedge clk) begin
    #1;
    if (pix_fire) pix_cnt++;
    pix_data = pix_val(pix_cnt);
    if (!pix_valid || pix_fire) pix_valid = throttle ? lfsr[0] : 1'b1;
    out_ready = throttle ? (lfsr[1] | lfsr[3]) : 1'b1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
  end

  task automatic push_hdr(logic [5:0] dt, logic [15:0] wc);
    logic [23:0] h;
    h = {wc, 2'(c_vc), dt};
    exp_q.push_back(h[7:0]);
    exp_q.push_back(h[15:8]);
    exp_q.push_back(h[23:16]);
    exp_q.push_back(ecc_ref(h));
  endtask

  task automatic push_long(logic [5:0] dt, int wc, bit pix);
    push_hdr(dt, 16'(wc));
    for (int i = 0; i < wc; i++) begin
      if (pix) begin exp_q.push_back(pix_val(mdl_pix)); mdl_pix++; end
      else exp_q.push_back(8'h00);
    end
    exp_q.push_back(8'h00);
    exp_q.push_back(8'h00);
  endtask

  task automatic build_exp();
    mdl_pix = pix_cnt;
    exp_q.delete();
    for (int r = 0; r < 4; r++) begin
      int n;
      n = (r == 0) ? c_vsa : (r == 1) ? c_vbp : (r == 2) ? c_vact : c_vfp;
      for (int i = 0; i < n; i++) begin
        logic [5:0] sdt;
        sdt = (i == 0 && r == 0) ? 6'h01 : (i == 0 && r == 1) ? 6'h11 : 6'h21;
        push_hdr(sdt, 16'h0);
        if (c_sev == 0) begin
          push_long(6'h19, c_hsa, 0);
          push_hdr(6'h31, 16'h0);
        end
        if (r == 2) begin
          push_long(6'h19, c_hbp, 0);
          push_long(6'h3E, c_hact, 1);
          push_long(6'h19, c_hfp, 0);
        end else begin
          push_long(6'h19, c_bllp, 0);
        end
      end
    end
  endtask

  task automatic drive_cfg();
    sync_event = 1'(c_sev); vchan = 2'(c_vc);
    vsa_lines = LW'(c_vsa); vbp_lines = LW'(c_vbp);
    act_lines = LW'(c_vact); vfp_lines = LW'(c_vfp);
    hsa_wc = 16'(c_hsa); hbp_wc = 16'(c_hbp); hact_wc = 16'(c_hact);
    hfp_wc = 16'(c_hfp); bllp_wc = 16'(c_bllp);
  endtask

  task automatic pulse_start();
    @(posedge clk); #2 start = 1'b1;
    @(posedge clk); #2 start = 1'b0;
  endtask

  task automatic run_frame(bit mid_start, string req);
    int bad;
    build_exp();
    got_q.delete();
    drive_cfg();
    pulse_start();
    @(negedge clk);
    chk(busy == 1'b1, "R11 busy after start", busy, 1);
    if (mid_start) begin
      repeat (20) @(posedge clk);
      #2;
      bllp_wc = bllp_wc + 16'd1; vchan = ~vchan; hact_wc = 16'd5;
      start = 1'b1;
      @(posedge clk); #2 start = 1'b0;
      @(negedge clk);
      chk(cfg_err == 1'b0, "R8 start during frame ignored", cfg_err, 0);
    end
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(got_q.size() == exp_q.size(), {req, " byte count"}, got_q.size(), exp_q.size());
    bad = -1;
    for (int i = 0; i < got_q.size() && i < exp_q.size(); i++)
      if (bad < 0 && got_q[i] !== exp_q[i]) bad = i;
    chk(bad < 0, {req, " stream content"},
        (bad < 0) ? 0 : int'(got_q[bad]), (bad < 0) ? 0 : int'(exp_q[bad]));
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(busy == 1'b0 && out_valid == 1'b0, "R11 reset outputs idle", busy, 0);
    chk(cfg_err == 1'b0 && pix_ready == 1'b0, "R11 reset flags clear", cfg_err, 0);
    @(posedge clk); #2 rst_n = 1'b1;
    repeat (2) @(posedge clk);
  endtask

  task automatic t_pulse_frame();
    int p0;
    c_sev = 0; c_vc = 0; c_vsa = 2; c_vbp = 2; c_vact = 2; c_vfp = 1;
    c_hsa = 2; c_hbp = 1; c_hact = 6; c_hfp = 2; c_bllp = 9;
    throttle = 0;
    p0 = pix_cnt;
    run_frame(0, "R1 R3 R4 pulse frame");
    chk(got_q.size() > 66, "R1 frame length", got_q.size(), 67);
    if (got_q.size() > 66) begin
      chk({got_q[0], got_q[1], got_q[2], got_q[3]} == 32'h01000007,
          "R2 R6 first sync packet", got_q[3], 8'h07);
      chk({got_q[31], got_q[32], got_q[33], got_q[34]} == 32'h21000012,
          "R5 R6 second line sync start", got_q[34], 8'h12);
      chk({got_q[62], got_q[63], got_q[64], got_q[65]} == 32'h11000014,
          "R2 back porch first line", got_q[62], 8'h11);
    end
    chk(pix_cnt - p0 == 12, "R3 pixel bytes consumed", pix_cnt - p0, 12);
  endtask

  task automatic t_event_frame();
    c_sev = 1; c_vc = 2; c_vsa = 1; c_vbp = 1; c_vact = 3; c_vfp = 2;
    c_hsa = 4; c_hbp = 2; c_hact = 9; c_hfp = 1; c_bllp = 12;
    throttle = 1;
    run_frame(1, "R7 R8 R10 event frame throttled");
    if (got_q.size() > 4)
      chk(got_q[4] == 8'h99, "R7 blanking follows sync start", got_q[4], 8'h99);
    throttle = 0;
  endtask

  task automatic t_bad(int hact, int bllp, int vact, string req);
    c_sev = 0; c_vc = 0; c_vsa = 1; c_vbp = 1; c_vact = vact; c_vfp = 1;
    c_hsa = 1; c_hbp = 1; c_hact = hact; c_hfp = 1; c_bllp = bllp;
    got_q.delete();
    drive_cfg();
    pulse_start();
    @(negedge clk);
    chk(cfg_err == 1'b1 && busy == 1'b0, {req, " error flagged"}, cfg_err, 1);
    repeat (20) @(negedge clk);
    chk(got_q.size() == 0, {req, " no bytes"}, got_q.size(), 0);
  endtask

  task automatic t_bad_cfg();
    t_bad(3, 6, 1, "R9 bllp mismatch");
    t_bad(4, 6, 1, "R9 hact not multiple of 3");
    t_bad(3, 5, 0, "R9 zero active lines");
    c_sev = 0; c_vc = 3; c_vsa = 1; c_vbp = 0; c_vact = 1; c_vfp = 1;
    c_hsa = 0; c_hbp = 0; c_hact = 3; c_hfp = 0; c_bllp = 3;
    run_frame(0, "R9 recovery frame");
    chk(cfg_err == 1'b0, "R9 error cleared", cfg_err, 0);
  endtask

  task automatic t_skip_regions();
    c_sev = 0; c_vc = 1; c_vsa = 0; c_vbp = 1; c_vact = 1; c_vfp = 0;
    c_hsa = 0; c_hbp = 0; c_hact = 3; c_hfp = 0; c_bllp = 3;
    run_frame(0, "R12 skipped regions");
    if (got_q.size() > 0)
      chk(got_q[0] == 8'h51, "R12 frame opens with back porch start", got_q[0], 8'h51);
  endtask

  initial begin
    t_reset();
    t_pulse_frame();
    t_event_frame();
    t_bad_cfg();
    t_skip_regions();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule